// File: doc/BRIEF.md
# Power-Mode and Wake-Up Sequencer

This block decides when a small microcontroller core runs, idles or sleeps. It runs entirely from the always-on low-frequency clock. A halt strobe from the instruction decoder parks the core. If the idle-enable input is set, the core enters an idle state, where only the CPU is stalled and the system clock keeps running for the peripherals. If idle-enable is clear, the core enters a sleep state, where the high-frequency oscillator and the system clock gate are shut off. While the core runs, the clock-select input picks the high-frequency source (normal mode) or the low-frequency source (slow mode) as the system clock.

Four sources end a halt: an external reset, a falling edge on the wake pin, an interrupt request and a watchdog overflow. The wake pin is synchronized by two flops and then edge-detected. Each wake, and each reset-class event while running, produces a one-cycle event with a kind code. Leaving sleep always passes through a settling phase. During that phase the oscillator is re-enabled and the CPU stays stalled for a programmable number of cycles.

The block keeps a power-down flag and a timeout flag. With them, firmware can tell apart power-up, an external reset, a watchdog reset and a resume after an interrupt. The block also tells the watchdog when to clear and whether it may count.

Top module: `pm_ctrl_top`

## Requirements
- R1: After rst_n is released the core is running: cpu_stall=0, sys_clk_en=1, pdf_flag=0, to_flag=0, evt_valid=0, and hosc_en=1 when slow_sel=0.
- R2: While running, sys_sel_slow equals slow_sel and hosc_en equals the inverse of slow_sel.
- R3: A halt_req accepted with idle_en=1 enters idle: cpu_stall=1, sys_clk_en=1, hosc_en equal to the inverse of slow_sel.
- R4: A halt_req accepted with idle_en=0 enters sleep: cpu_stall=1, sys_clk_en=0, hosc_en=0.
- R5: An accepted halt sets pdf_flag, clears to_flag and raises wdt_clr for exactly the following cycle.
- R6: wdt_run is 1 when wdt_en=1 and the core is not asleep. In sleep, wdt_run equals wdt_en AND wdt_src_lf.
- R7: clr_wdt while running clears pdf_flag and raises wdt_clr for one cycle. It leaves to_flag unchanged.
- R8: In idle or sleep, irq=1, or a wake_pin falling edge seen through two synchronizer flops, causes a wake with evt_kind=2'b11 (resume). The flags are left unchanged. The pin edge acts on the third clock edge after the pin falls.
- R9: A wdt_ovf, while running or halted, sets to_flag and gives evt_kind=2'b10 (watchdog reset). pdf_flag is left unchanged. A halted core wakes.
- R10: ext_rst gives evt_kind=2'b01 (full reset) in any state, wakes a halted core, and leaves both flags unchanged.
- R11: A wake from sleep enters settling: cpu_stall=1, sys_clk_en=0, hosc_en equal to the inverse of slow_sel, for settle_len+1 cycles. Then cpu_stall falls.
- R12: A wake from idle returns to running on the same edge, with no settling.
- R13: Priority is ext_rst over wdt_ovf over halt_req (running) or over irq and pin edge (halted).
- R14: A wake_pin falling edge while running, or a rising edge while asleep, has no effect.
- Event codes: evt_valid is a one-cycle pulse registered on the edge of the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on low-frequency clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| halt_req | input | 1 | Halt strobe from instruction decode |
| clr_wdt | input | 1 | Clear-watchdog strobe |
| slow_sel | input | 1 | 1 selects the low-frequency system clock |
| idle_en | input | 1 | 1 makes halt enter idle instead of sleep |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_src_lf | input | 1 | Watchdog clocked from the low-frequency source |
| ext_rst | input | 1 | Synchronized external reset request |
| wake_pin | input | 1 | Asynchronous wake pin, active on falling edge |
| irq | input | 1 | Interrupt request |
| wdt_ovf | input | 1 | Watchdog overflow |
| settle_len | input | SETTLE_W | Settling cycles after a sleep wake, minus one |
| hosc_en | output | 1 | High-frequency oscillator enable |
| sys_sel_slow | output | 1 | System clock source select |
| sys_clk_en | output | 1 | System clock gate enable |
| cpu_stall | output | 1 | Holds the CPU |
| wdt_clr | output | 1 | Watchdog counter clear pulse |
| wdt_run | output | 1 | Watchdog count enable |
| pdf_flag | output | 1 | Power-down status flag |
| to_flag | output | 1 | Timeout status flag |
| evt_valid | output | 1 | Event pulse |
| evt_kind | output | 2 | 01 full reset, 10 watchdog reset, 11 resume |

## Verification
A halt strobe can arrive in the same cycle as a watchdog overflow or an external reset. A halted core can also see an interrupt and an overflow together. Directed cases drive each of these pairs in a single cycle. The resulting event kind, the flags and the stall are then compared with the priority of R13. Randomized halt and wake rounds repeat the same comparison against modelled flag values.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PM_RUN    = 2'd0,
    PM_IDLE   = 2'd1,
    PM_SLEEP  = 2'd2,
    PM_SETTLE = 2'd3
  } pm_state_e;

  typedef enum logic [1:0] {
    EV_NONE   = 2'b00,
    EV_FULL   = 2'b01,
    EV_WDOG   = 2'b10,
    EV_RESUME = 2'b11
  } pm_evt_e;
endpackage

// File: rtl/pm_fall_sync.sv
module pm_fall_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign fall = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/pm_settle_timer.sv
module pm_settle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  input  logic         count_en,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = len;
    else if (count_en && cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/pm_status_flags.sv
module pm_status_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_go,
  input  logic clr_pd,
  input  logic set_to,
  output logic pdf,
  output logic to
);
  logic pdf_d, to_d;

  always_comb begin
    pdf_d = pdf;
    to_d  = to;
    if (halt_go) begin
      pdf_d = 1'b1;
      to_d  = 1'b0;
    end else begin
      if (clr_pd) pdf_d = 1'b0;
      if (set_to) to_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdf <= 1'b0;
      to  <= 1'b0;
    end else begin
      pdf <= pdf_d;
      to  <= to_d;
    end
  end
endmodule

// File: rtl/pm_ctrl_top.sv
module pm_ctrl_top #(
  parameter int SETTLE_W  = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                halt_req,
  input  logic                clr_wdt,
  input  logic                slow_sel,
  input  logic                idle_en,
  input  logic                wdt_en,
  input  logic                wdt_src_lf,
  input  logic                ext_rst,
  input  logic                wake_pin,
  input  logic                irq,
  input  logic                wdt_ovf,
  input  logic [SETTLE_W-1:0] settle_len,
  output logic                hosc_en,
  output logic                sys_sel_slow,
  output logic                sys_clk_en,
  output logic                cpu_stall,
  output logic                wdt_clr,
  output logic                wdt_run,
  output logic                pdf_flag,
  output logic                to_flag,
  output logic                evt_valid,
  output logic [1:0]          evt_kind
);
  import pm_pkg::*;

  pm_state_e state_q, state_d;
  pm_evt_e   evt_d;
  logic      pin_fall, settle_done, settle_load;
  logic      halt_go, clr_pd, set_to, soft_wake;
  logic      wdt_clr_q, evt_valid_q;
  pm_evt_e   evt_kind_q;

  pm_fall_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(wake_pin), .fall(pin_fall)
  );

  pm_settle_timer #(.W(SETTLE_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .load(settle_load), .len(settle_len),
    .count_en(state_q == PM_SETTLE), .done(settle_done)
  );

  pm_status_flags u_flags (
    .clk(clk), .rst_n(rst_n), .halt_go(halt_go), .clr_pd(clr_pd),
    .set_to(set_to), .pdf(pdf_flag), .to(to_flag)
  );

  assign soft_wake = irq | pin_fall;

  always_comb begin
    state_d     = state_q;
    evt_d       = EV_NONE;
    halt_go     = 1'b0;
    clr_pd      = 1'b0;
    set_to      = 1'b0;
    settle_load = 1'b0;
    unique case (state_q)
      PM_RUN: begin
        if (ext_rst) begin
          evt_d = EV_FULL;
        end else if (wdt_ovf) begin
          evt_d  = EV_WDOG;
          set_to = 1'b1;
        end else if (halt_req) begin
          halt_go = 1'b1;
          state_d = idle_en ? PM_IDLE : PM_SLEEP;
        end else if (clr_wdt) begin
          clr_pd = 1'b1;
        end
      end
      PM_IDLE, PM_SLEEP: begin
        if (ext_rst) begin
          evt_d = EV_FULL;
        end else if (wdt_ovf) begin
          evt_d  = EV_WDOG;
          set_to = 1'b1;
        end else if (soft_wake) begin
          evt_d = EV_RESUME;
        end
        if (evt_d != EV_NONE) begin
          if (state_q == PM_SLEEP) begin
            state_d     = PM_SETTLE;
            settle_load = 1'b1;
          end else begin
            state_d = PM_RUN;
          end
        end
      end
      PM_SETTLE: begin
        if (ext_rst) evt_d = EV_FULL;
        if (settle_done) state_d = PM_RUN;
      end
      default: state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= PM_RUN;
      wdt_clr_q   <= 1'b0;
      evt_valid_q <= 1'b0;
      evt_kind_q  <= EV_NONE;
    end else begin
      state_q     <= state_d;
      wdt_clr_q   <= halt_go | clr_pd;
      evt_valid_q <= (evt_d != EV_NONE);
      evt_kind_q  <= evt_d;
    end
  end

  assign cpu_stall    = (state_q != PM_RUN);
  assign sys_clk_en   = (state_q == PM_RUN) || (state_q == PM_IDLE);
  assign hosc_en      = (state_q != PM_SLEEP) && !slow_sel;
  assign sys_sel_slow = slow_sel;
  assign wdt_run      = wdt_en && ((state_q != PM_SLEEP) || wdt_src_lf);
  assign wdt_clr      = wdt_clr_q;
  assign evt_valid    = evt_valid_q;
  assign evt_kind     = evt_kind_q;
endmodule

// File: rtl/pm_ctrl_chk.sv
module pm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       halt_req,
  input logic       ext_rst,
  input logic       wdt_ovf,
  input logic       wdt_en,
  input logic       cpu_stall,
  input logic       sys_clk_en,
  input logic       wdt_clr,
  input logic       wdt_run,
  input logic       pdf_flag,
  input logic       to_flag,
  input logic       evt_valid,
  input logic [1:0] evt_kind
);
  // R5
  halt_sets_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !cpu_stall && !ext_rst && !wdt_ovf) |=> (pdf_flag && !to_flag && wdt_clr));

  // R8
  resume_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == 2'b11) |-> ($stable(pdf_flag) && $stable(to_flag)));

  // R9
  wdog_sets_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == 2'b10) |-> (to_flag && $stable(pdf_flag)));

  // R10
  full_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == 2'b01) |-> ($stable(pdf_flag) && $stable(to_flag)));

  // R4
  gated_means_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_clk_en |-> cpu_stall);

  // R6
  wdt_run_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_run |-> wdt_en);

  // R13
  reset_beats_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rst && !cpu_stall) |=> (!cpu_stall && evt_valid && evt_kind == 2'b01));
endmodule

bind pm_ctrl_top pm_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .ext_rst(ext_rst),
  .wdt_ovf(wdt_ovf), .wdt_en(wdt_en), .cpu_stall(cpu_stall),
  .sys_clk_en(sys_clk_en), .wdt_clr(wdt_clr), .wdt_run(wdt_run),
  .pdf_flag(pdf_flag), .to_flag(to_flag), .evt_valid(evt_valid),
  .evt_kind(evt_kind)
);

// File: tb/tb_pm_ctrl_top.sv
module tb_pm_ctrl_top;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_n, halt_req, clr_wdt, slow_sel, idle_en, wdt_en, wdt_src_lf;
  logic ext_rst, wake_pin, irq, wdt_ovf;
  logic [SW-1:0] settle_len;
  logic hosc_en, sys_sel_slow, sys_clk_en, cpu_stall, wdt_clr, wdt_run;
  logic pdf_flag, to_flag, evt_valid;
  logic [1:0] evt_kind;

  int checks = 0;
  int fails  = 0;
  bit m_pdf, m_to;

  always #5 clk = ~clk;

  pm_ctrl_top #(.SETTLE_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .clr_wdt(clr_wdt),
    .slow_sel(slow_sel), .idle_en(idle_en), .wdt_en(wdt_en),
    .wdt_src_lf(wdt_src_lf), .ext_rst(ext_rst), .wake_pin(wake_pin),
    .irq(irq), .wdt_ovf(wdt_ovf), .settle_len(settle_len),
    .hosc_en(hosc_en), .sys_sel_slow(sys_sel_slow), .sys_clk_en(sys_clk_en),
    .cpu_stall(cpu_stall), .wdt_clr(wdt_clr), .wdt_run(wdt_run),
    .pdf_flag(pdf_flag), .to_flag(to_flag), .evt_valid(evt_valid),
    .evt_kind(evt_kind)
  );

  function automatic int exp_kind(int w);
    case (w)
      0, 1:    return 3;
      2:       return 2;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_halt(input bit idl);
    idle_en = idl; halt_req = 1'b1; cyc(); halt_req = 1'b0;
    m_pdf = 1'b1; m_to = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; halt_req = 0; clr_wdt = 0; slow_sel = 0; idle_en = 0;
    wdt_en = 1; wdt_src_lf = 0; ext_rst = 0; wake_pin = 1; irq = 0;
    wdt_ovf = 0; settle_len = '0;
    m_pdf = 0; m_to = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1
    chk("R1 stall", cpu_stall, 0);
    chk("R1 clk_en", sys_clk_en, 1);
    chk("R1 pdf", pdf_flag, 0);
    chk("R1 to", to_flag, 0);
    chk("R1 hosc", hosc_en, 1);
    chk("R1 evt", evt_valid, 0);
    // R2
    slow_sel = 1; cyc();
    chk("R2 sel", sys_sel_slow, 1);
    chk("R2 hosc", hosc_en, 0);
    slow_sel = 0; cyc();
    chk("R2 hosc back", hosc_en, 1);
    // R3 R5 idle entry
    do_halt(1);
    chk("R3 stall", cpu_stall, 1);
    chk("R3 clk_en", sys_clk_en, 1);
    chk("R3 hosc", hosc_en, 1);
    chk("R5 pdf", pdf_flag, 1);
    chk("R5 to", to_flag, 0);
    chk("R5 wdt_clr", wdt_clr, 1);
    cyc();
    chk("R5 wdt_clr one cycle", wdt_clr, 0);
    // R12 R8 idle wake by irq
    irq = 1; cyc(); irq = 0;
    chk("R8 evt", evt_valid, 1);
    chk("R8 kind", evt_kind, 3);
    chk("R8 pdf kept", pdf_flag, 1);
    chk("R12 no settle", cpu_stall, 0);
    // R7
    clr_wdt = 1; cyc(); clr_wdt = 0;
    chk("R7 pdf", pdf_flag, 0);
    chk("R7 wdt_clr", wdt_clr, 1);
    chk("R7 to", to_flag, 0);
    // R9 overflow while running
    wdt_ovf = 1; cyc(); wdt_ovf = 0;
    chk("R9 run kind", evt_kind, 2);
    chk("R9 run to", to_flag, 1);
    chk("R9 run pdf", pdf_flag, 0);
    chk("R9 run stall", cpu_stall, 0);
    // R4 sleep entry and R6
    do_halt(0);
    chk("R5 to cleared", to_flag, 0);
    chk("R4 stall", cpu_stall, 1);
    chk("R4 hosc", hosc_en, 0);
    chk("R4 clk_en", sys_clk_en, 0);
    chk("R6 sleep sys src", wdt_run, 0);
    wdt_src_lf = 1; #1;
    chk("R6 sleep lf src", wdt_run, 1);
    wdt_src_lf = 0;
    // R9 R11 watchdog wake with settling
    settle_len = 3;
    wdt_ovf = 1; cyc(); wdt_ovf = 0;
    chk("R9 kind", evt_kind, 2);
    chk("R9 to", to_flag, 1);
    chk("R9 pdf", pdf_flag, 1);
    chk("R11 hosc", hosc_en, 1);
    chk("R11 clk_en", sys_clk_en, 0);
    cyc(3);
    chk("R11 still stalled", cpu_stall, 1);
    cyc();
    chk("R11 released", cpu_stall, 0);
    chk("R6 running", wdt_run, 1);
    settle_len = 0;
    // R8 pin falling edge wake from sleep
    do_halt(0);
    wake_pin = 0; cyc(2);
    chk("R8 pin not yet", evt_valid, 0);
    cyc();
    chk("R8 pin evt", evt_valid, 1);
    chk("R8 pin kind", evt_kind, 3);
    cyc();
    chk("R11 zero settle", cpu_stall, 0);
    wake_pin = 1; cyc(3);
    // R14 falling edge while running
    wake_pin = 0;
    for (int i = 0; i < 4; i++) begin
      cyc();
      chk("R14 run edge evt", evt_valid, 0);
    end
    // R14 rising edge while asleep
    do_halt(0);
    wake_pin = 1; cyc(4);
    chk("R14 rise stall", cpu_stall, 1);
    chk("R14 rise evt", evt_valid, 0);
    // R10 external reset in sleep
    ext_rst = 1; cyc(); ext_rst = 0;
    chk("R10 kind", evt_kind, 1);
    chk("R10 pdf kept", pdf_flag, 1);
    chk("R10 to kept", to_flag, 0);
    cyc();
    chk("R10 woke", cpu_stall, 0);
    // R13 halt with ext_rst
    halt_req = 1; ext_rst = 1; idle_en = 0; cyc(); halt_req = 0; ext_rst = 0;
    chk("R13 rst over halt kind", evt_kind, 1);
    chk("R13 rst over halt stall", cpu_stall, 0);
    // R13 halt with overflow
    halt_req = 1; wdt_ovf = 1; cyc(); halt_req = 0; wdt_ovf = 0;
    chk("R13 ovf over halt kind", evt_kind, 2);
    chk("R13 ovf over halt stall", cpu_stall, 0);
    chk("R13 ovf over halt to", to_flag, 1);
    // R13 halted: irq with overflow
    do_halt(1);
    irq = 1; wdt_ovf = 1; cyc(); irq = 0; wdt_ovf = 0;
    chk("R13 ovf over irq kind", evt_kind, 2);
    m_to = 1;

    // randomized rounds
    void'($urandom(32'h5eed1234));
    for (int it = 0; it < 40; it++) begin
      bit idl, slw;
      int len, w;
      idl = $urandom % 2; slw = $urandom % 2;
      len = $urandom % 4; w = $urandom % 4;
      slow_sel = slw; settle_len = len[SW-1:0];
      do_halt(idl);
      chk("R3R4 stall", cpu_stall, 1);
      chk("R5 pdf", pdf_flag, m_pdf);
      chk("R5 to", to_flag, m_to);
      chk("R3R4 hosc", hosc_en, idl ? !slw : 0);
      case (w)
        0: begin irq = 1; cyc(); irq = 0; end
        1: begin wake_pin = 0; cyc(3); end
        2: begin wdt_ovf = 1; cyc(); wdt_ovf = 0; end
        default: begin ext_rst = 1; cyc(); ext_rst = 0; end
      endcase
      if (w == 2) m_to = 1'b1;
      chk("R8R9R10 evt", evt_valid, 1);
      chk("R8R9R10 kind", evt_kind, exp_kind(w));
      chk("R8R9R10 to", to_flag, m_to);
      chk("R8R9R10 pdf", pdf_flag, m_pdf);
      if (!idl) begin
        for (int k = 0; k <= len; k++) begin
          chk("R11 settle stall", cpu_stall, 1);
          cyc();
        end
      end
      chk("R11R12 released", cpu_stall, 0);
      if (w == 1) begin wake_pin = 1; cyc(3); end
      cyc();
    end
    finish_run();
  end
endmodule